// File: doc/BRIEF.md
# Keyed Reset Watchdog

This block is a watchdog for system recovery. A prescaler divides the system clock down to a slow tick of about 16 kHz. A 20-bit counter counts down once per tick. Software writes two 32-bit registers: a timeout register and a control register. A write takes effect only when its top byte carries the key value 0x5A. Any write with a different top byte is dropped, so a stray store cannot arm, kick or stop the watchdog.

To start the watchdog, software loads a tick count and then writes a reset kind into the control register. Writing the timeout register again while the watchdog runs reloads the counter; this is the kick. A special stop code halts the countdown. When the count runs out, the block does four things:

- it raises a reset request for a fixed number of clocks;
- it shows the chosen reset kind while the request is high;
- it sets a sticky flag saying the watchdog caused the reset;
- it returns to the stopped state.

A forced reboot is a load of a very small count followed by a full-reset control write.

Top module: `guarded_wdog`

## Requirements
- R1: A write to either register changes nothing unless `wr_data[31:24]` equals 0x5A.
- R2: A keyed write with `wr_sel`=0 loads `wr_data[19:0]` as the tick count. Upper data bits are dropped. With `rd_sel`=0, `rd_data` returns the remaining count in bits [19:0], and bits [31:20] read as zero.
- R3: A keyed control write (`wr_sel`=1) that is not the stop code stores `wr_data[5:4]` as the reset kind. The value 2'b10 means full reset. A nonzero kind starts the countdown and 2'b00 halts it. With `rd_sel`=1, the read word has bit 0 = running, bits [5:4] = kind and bit 6 = watchdog-reset flag; all other bits are zero.
- R4: A keyed control write whose bits [11:0] equal 0x102 stops the countdown. The remaining count and the stored kind are kept.
- R5: While running, the count drops by one every TICK_DIV clocks. Every accepted write restarts the prescaler, so the first decrement comes TICK_DIV clocks after the write.
- R6: A keyed timeout write while running reloads the count and postpones expiry by the full new timeout.
- R7: When a tick finds a running count of 1 or 0, the count becomes 0 and the block stops. `rst_req` goes high from the next clock for exactly PULSE_LEN clocks, and `rst_kind` shows the stored kind during those clocks (0 otherwise).
- R8: Expiry sets the watchdog-reset flag. A keyed control write with bit 6 set clears it.
- R9: After reset the count is 0, the block is stopped, the kind and the flag are 0, and `rst_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 timeout, 1 control |
| wr_data | input | 32 | Write data, key in bits [31:24] |
| rd_sel | input | 1 | Read select: 0 remaining count, 1 control/status |
| rd_data | output | 32 | Read data |
| rst_req | output | 1 | Reset request pulse |
| rst_kind | output | 2 | Reset kind, valid while rst_req is high |

## Verification
On every cycle, the assertions check four things. A stopped counter only changes on a keyed load. A running counter steps down by exactly one per tick. The stop code always leaves the block stopped. The start of a reset pulse always comes with the flag set and the countdown halted.

Some behaviour needs the bench's timed scenarios, which sample at computed clock offsets:

- the exact cycle at which the pulse starts;
- the pulse length;
- the delay after a kick;
- whether unkeyed writes leave the readback untouched;
- field placement in the read words.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0]  WD_KEY  = 8'h5A;
  localparam logic [11:0] WD_HALT = 12'h102;

  function automatic logic key_ok(input logic [31:0] d);
    return d[31:24] == WD_KEY;
  endfunction

  function automatic logic is_halt(input logic [31:0] d);
    return d[11:0] == WD_HALT;
  endfunction

  function automatic logic [1:0] kind_of(input logic [31:0] d);
    return d[5:4];
  endfunction

  function automatic logic [31:0] ctl_word(input logic flag, input logic [1:0] kind,
                                           input logic run);
    return {25'd0, flag, kind, 3'd0, run};
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [PW-1:0] pc;

  assign tick = (pc == PW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pc <= '0;
    else if (restart || tick) pc <= '0;
    else                     pc <= pc + 1'b1;
  end
endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import wdog_pkg::*;
#(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [31:0]   wr_data,
  output logic          ld,
  output logic [CW-1:0] ld_val,
  output logic          ctl,
  output logic          halt,
  output logic          go,
  output logic          clr_flag,
  output logic [1:0]    kind_cfg
);
  logic keyed;

  assign keyed    = wr_en && key_ok(wr_data);
  assign ld       = keyed && !wr_sel;
  assign ctl      = keyed && wr_sel;
  assign halt     = ctl && is_halt(wr_data);
  assign go       = ctl && !halt && (kind_of(wr_data) != 2'b00);
  assign clr_flag = ctl && wr_data[6];
  assign ld_val   = wr_data[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            kind_cfg <= 2'b00;
    else if (ctl && !halt) kind_cfg <= kind_of(wr_data);
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          ctl,
  input  logic          go,
  output logic [CW-1:0] cnt,
  output logic          run,
  output logic          expire
);
  assign expire = run && tick && (cnt <= CW'(1)) && !ld && !ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (ld)                         cnt <= ld_val;
    else if (run && tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= 1'b0;
    else if (ctl)    run <= go;
    else if (expire) run <= 1'b0;
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       clr_flag,
  input  logic [1:0] kind_cfg,
  output logic       rst_req,
  output logic [1:0] rst_kind,
  output logic       flag
);
  localparam int PCW = $clog2(PULSE_LEN + 1);
  logic [PCW-1:0] pcnt;
  logic [1:0]     kind_hold;

  assign rst_req  = (pcnt != '0);
  assign rst_kind = rst_req ? kind_hold : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt      <= '0;
      kind_hold <= 2'b00;
    end else if (expire) begin
      pcnt      <= PCW'(PULSE_LEN);
      kind_hold <= kind_cfg;
    end else if (pcnt != '0) begin
      pcnt      <= pcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (expire)   flag <= 1'b1;
    else if (clr_flag) flag <= 1'b0;
  end
endmodule

// File: rtl/guarded_wdog.sv
module guarded_wdog
  import wdog_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int TICK_DIV  = 3125,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        rst_req,
  output logic [1:0]  rst_kind
);
  logic             tick, ld, ctl, halt, go, clr_flag, run, expire, flag;
  logic [CNT_W-1:0] ld_val, cnt;
  logic [1:0]       kind_cfg;

  wdog_regfile #(.CW(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ld(ld), .ld_val(ld_val), .ctl(ctl), .halt(halt), .go(go),
    .clr_flag(clr_flag), .kind_cfg(kind_cfg));

  wdog_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ld || ctl), .tick(tick));

  wdog_count #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld), .ld_val(ld_val),
    .ctl(ctl), .go(go), .cnt(cnt), .run(run), .expire(expire));

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pls (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_flag(clr_flag),
    .kind_cfg(kind_cfg), .rst_req(rst_req), .rst_kind(rst_kind), .flag(flag));

  assign rd_data = rd_sel ? ctl_word(flag, kind_cfg, run)
                          : {{(32-CNT_W){1'b0}}, cnt};
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ld,
  input logic          ctl,
  input logic          halt,
  input logic          run,
  input logic [CW-1:0] cnt,
  input logic          rst_req,
  input logic          flag
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt)); // R1

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !ld && cnt > CW'(1)) |=> (cnt == $past(cnt) - 1'b1)); // R5

  AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl && halt) |=> !run); // R4

  AST_PULSE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> !run); // R7

  AST_FLAG_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> flag); // R8
endmodule

bind guarded_wdog wdog_checker #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld), .ctl(ctl), .halt(halt),
  .run(run), .cnt(cnt), .rst_req(rst_req), .flag(flag));

// File: tb/sim_guarded_wdog.sv
module sim_guarded_wdog;
  localparam int DIV = 4;
  localparam int PL  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rst_req;
  logic [1:0]  rst_kind;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  guarded_wdog #(.CNT_W(20), .TICK_DIV(DIV), .PULSE_LEN(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .rst_req(rst_req), .rst_kind(rst_kind));

  // {sel, data, expected count readback, expected control readback[6:0]}
  localparam logic [59:0] VEC [6] = '{
    {1'b0, 32'h5A01_2345, 20'h12345, 7'h00},
    {1'b0, 32'h5B0A_BCDE, 20'h12345, 7'h00},
    {1'b0, 32'h5AFF_FFFF, 20'hFFFFF, 7'h00},
    {1'b1, 32'hA500_0020, 20'hFFFFF, 7'h00},
    {1'b0, 32'h0000_0007, 20'hFFFFF, 7'h00},
    {1'b0, 32'h5A00_0000, 20'h00000, 7'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    rd(1'b0, v); check("R9 count", v, 32'h0);
    rd(1'b1, v); check("R9 ctl", v, 32'h0);
    check("R9 req", {31'd0, rst_req}, 32'h0);
    check("R9 kind", {30'd0, rst_kind}, 32'h0);

    // vector table: R1 key filtering, R2 load width
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][59], VEC[i][58:27]);
      rd(1'b0, v); check("R1/R2 table count", v, {12'd0, VEC[i][26:7]});
      rd(1'b1, v); check("R1/R3 table ctl", v, {25'd0, VEC[i][6:0]});
    end

    // R3/R5/R7/R8 expiry with full reset
    wr(1'b0, 32'h5A00_0003);
    wr(1'b1, 32'h5A00_0020);
    rd(1'b1, v); check("R3 ctl running full", v, 32'h21);
    rd(1'b0, v); check("R2 count", v, 32'd3);
    repeat (4) @(negedge clk);
    rd(1'b0, v); check("R5 one step", v, 32'd2);
    repeat (7) @(negedge clk);
    check("R7 no early pulse", {31'd0, rst_req}, 32'h0);
    @(negedge clk);
    check("R7 pulse start", {31'd0, rst_req}, 32'h1);
    check("R7 kind full", {30'd0, rst_kind}, 32'h2);
    repeat (3) @(negedge clk);
    check("R7 pulse held", {31'd0, rst_req}, 32'h1);
    @(negedge clk);
    check("R7 pulse end", {31'd0, rst_req}, 32'h0);
    check("R7 kind idle", {30'd0, rst_kind}, 32'h0);
    rd(1'b1, v); check("R8 flag set stopped", v, 32'h60);
    rd(1'b0, v); check("R7 count zero", v, 32'h0);

    // R8 clear
    wr(1'b1, 32'h5A00_0040);
    rd(1'b1, v); check("R8 flag cleared", v, 32'h0);

    // R6 kick
    wr(1'b0, 32'h5A00_000A);
    wr(1'b1, 32'h5A00_0010);
    repeat (20) @(negedge clk);
    rd(1'b0, v); check("R5 count after 5 ticks", v, 32'd5);
    wr(1'b0, 32'h5A00_000A);
    rd(1'b0, v); check("R6 reloaded", v, 32'd10);
    repeat (39) @(negedge clk);
    check("R6 no pulse before new timeout", {31'd0, rst_req}, 32'h0);
    rd(1'b0, v); check("R6 count one", v, 32'd1);
    @(negedge clk);
    check("R6 pulse after kick", {31'd0, rst_req}, 32'h1);
    check("R7 kind one", {30'd0, rst_kind}, 32'h1);
    repeat (6) @(negedge clk);
    wr(1'b1, 32'h5A00_0040);

    // R4 stop code
    wr(1'b0, 32'h5A00_0008);
    wr(1'b1, 32'h5A00_0030);
    repeat (8) @(negedge clk);
    rd(1'b0, v); check("R5 count six", v, 32'd6);
    wr(1'b1, 32'h5A00_0102);
    rd(1'b1, v); check("R4 stopped kind kept", v, 32'h30);
    repeat (40) @(negedge clk);
    rd(1'b0, v); check("R4 count frozen", v, 32'd6);
    check("R4 no pulse", {31'd0, rst_req}, 32'h0);
    wr(1'b1, 32'h0000_0020);
    repeat (20) @(negedge clk);
    rd(1'b1, v); check("R1 unkeyed start ignored", v, 32'h30);
    rd(1'b0, v); check("R1 count still frozen", v, 32'd6);

    // R1 unkeyed kick while running
    wr(1'b0, 32'h5A00_0005);
    wr(1'b1, 32'h5A00_0010);
    wr(1'b0, 32'h1100_0050);
    rd(1'b0, v); check("R1 unkeyed kick ignored", v, 32'd5);
    repeat (2) @(negedge clk);
    rd(1'b0, v); check("R1 count keeps falling", v, 32'd4);
    repeat (30) @(negedge clk);
    finish_run();
  end
endmodule